// File: doc/BRIEF.md
# Blanked Cycle-by-Cycle Current Limiter

This block decides when the active lower-switch pulse of a full-bridge modulator must stop. The steering generator tells it whether a lower output pulse is on. Two digital comparator flags arrive with that level. One says the sensed current is above the limit. The other says the modulation ramp has crossed the error level. A third flag says the error level is below the zero-duty threshold. From these inputs the block produces a one-cycle terminate strobe that goes back to the steering generator.

Each new pulse opens with a programmable blanking window. During that window only the overcurrent flag is masked, so switching spikes at turn-on cannot cut the pulse short. The ramp trip and the zero-duty condition are never masked.

Whenever a pulse ends, the block drives a discharge level that shorts the sense and ramp nodes. A pulse ends either by a trip or because the steering generator drops it. The discharge level stays high for a programmable minimum number of clocks and is released only once a new pulse has begun. Overcurrent never latches the converter off: each pulse simply becomes shorter. A sticky flag records that at least one pulse was cut by overcurrent since the flag was last cleared.

Top module: `pulse_limit`

## Requirements
- R1: During and right after reset, `end_pulse` is 0, `node_reset` is 1 and `oc_seen` is 0.
- R2: `oc_flag` is ignored for exactly `blank_len` clock cycles, counted from the first cycle in which `pulse_on` is seen high after being low. A `blank_len` of 0 means no blanking.
- R3: When `oc_flag` is high in a cycle of a running pulse and blanking is over, `end_pulse` is high in the next cycle. With overcurrent present from the start, the strobe therefore comes `blank_len`+1 cycles after the pulse starts.
- R4: When `ramp_trip` is high in a cycle of a running pulse, `end_pulse` is high in the next cycle. Blanking has no effect on this path.
- R5: `node_reset` is high in the cycle after any pulse end. A pulse ends either by a trip or by `pulse_on` falling while the pulse is still running.
- R6: Once set, `node_reset` stays high for at least max(`hold_len`,1) cycles. It falls one cycle after the first cycle in which both of these are true: the hold time has expired, and a new pulse start has been seen since the node reset began.
- R7: When `err_low` is high in the first cycle of a pulse, `end_pulse` is high in the next cycle, which gives a zero-width pulse.
- R8: `oc_seen` goes to 1 in the cycle after an overcurrent termination. It goes to 0 in the cycle after `oc_clr` is high. If both happen in the same cycle, the set wins.
- R9: Sustained overcurrent never latches: every later pulse again runs for its blanking window and is then cut by a strobe.
- R10: After a termination, `end_pulse` stays 0 until `pulse_on` has fallen and risen again, even if the trip flags stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_on | input | 1 | A lower output pulse is being driven by the steering generator |
| oc_flag | input | 1 | Current sense above the limit |
| ramp_trip | input | 1 | Modulation ramp above the error level |
| err_low | input | 1 | Error level below the zero-duty threshold |
| blank_len | input | CNT_W | Blanking window length in clocks |
| hold_len | input | CNT_W | Minimum node-discharge time in clocks |
| oc_clr | input | 1 | Clears the sticky overcurrent flag |
| end_pulse | output | 1 | One-cycle terminate strobe to the steering generator |
| node_reset | output | 1 | Discharge level for the sense and ramp nodes |
| oc_seen | output | 1 | Sticky flag: a pulse was cut by overcurrent |

## Verification
The bench builds the block with a counter width of 4. This keeps the blanking and hold counters small enough that each one can be driven through its load, its count-down and its expiry within a few cycles. The bench runs the blanking window at 3 and at 0, which covers both a masked start and a start with an immediate overcurrent cut. It runs the hold time at 2 and at 4. With 4, a new pulse arrives while the discharge is still being held, so the release has to wait for the counter rather than for the pulse start.

// File: rtl/clim_pkg.sv
package clim_pkg;

    // Events derived from the pulse level each cycle
    typedef struct packed {
        logic rise;         // first cycle of a new pulse
        logic live;         // pulse running and not yet terminated
        logic natural_end;  // pulse dropped by the steering logic, not by a trip
    } pulse_ev_t;

    // Trip causes in the current cycle
    typedef struct packed {
        logic oc;   // unblanked overcurrent
        logic pwm;  // ramp crossing or zero-duty request
    } trip_t;

    typedef enum logic {
        NODES_OPEN    = 1'b0,
        NODES_SHORTED = 1'b1
    } node_state_e;

    // Counter preload so that a length of N spans N cycles (0 and 1 both give one cycle)
    function automatic int unsigned span_load(int unsigned len);
        return (len == 0) ? 0 : len - 1;
    endfunction

endpackage

// File: rtl/clim_pulse_track.sv
module clim_pulse_track
    import clim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pulse_on,
    input  logic      trip,
    output pulse_ev_t ev
);

    logic on_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            on_q <= pulse_on;
            if (trip)
                done_q <= 1'b1;
            else if (pulse_on && !on_q)
                done_q <= 1'b0;
        end
    end

    always_comb begin
        ev.rise        = pulse_on & ~on_q;
        ev.live        = pulse_on & (ev.rise | ~done_q);
        ev.natural_end = on_q & ~pulse_on & ~done_q;
    end

    AST_NO_LIVE_AFTER_TRIP: assert property (@(posedge clk) disable iff (rst)
        trip |=> (!ev.live || ev.rise)); // R10

endmodule

// File: rtl/clim_blank.sv
module clim_blank
    import clim_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [CNT_W-1:0] blank_len,
    output logic             blank_act
);

    logic [CNT_W-1:0] cnt_q;

    always_comb
        blank_act = (rise && blank_len != '0) || (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (rise)
            cnt_q <= CNT_W'(span_load(32'(blank_len)));
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    AST_BLANK_SPANS: assert property (@(posedge clk) disable iff (rst)
        (rise && blank_len > CNT_W'(1)) |=> blank_act); // R2

endmodule

// File: rtl/clim_trip.sv
module clim_trip
    import clim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic blank_act,
    input  logic oc_flag,
    input  logic ramp_trip,
    input  logic err_low,
    input  logic oc_clr,
    output logic trip,
    output logic end_pulse,
    output logic oc_seen
);

    trip_t tr;

    always_comb begin
        tr.oc  = live & oc_flag & ~blank_act;
        tr.pwm = live & (ramp_trip | err_low);
        trip   = tr.oc | tr.pwm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            end_pulse <= 1'b0;
            oc_seen   <= 1'b0;
        end else begin
            end_pulse <= trip;
            if (tr.oc)
                oc_seen <= 1'b1;
            else if (oc_clr)
                oc_seen <= 1'b0;
        end
    end

    AST_BLANK_MASKS: assert property (@(posedge clk) disable iff (rst)
        (blank_act && !ramp_trip && !err_low) |=> !end_pulse); // R2
    AST_OC_ENDS: assert property (@(posedge clk) disable iff (rst)
        (live && oc_flag && !blank_act) |=> end_pulse); // R3
    AST_RAMP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (live && ramp_trip) |=> end_pulse); // R4
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (live && err_low) |=> end_pulse); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (oc_seen && !oc_clr) |=> oc_seen); // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        end_pulse |=> !end_pulse); // R10

endmodule

// File: rtl/clim_discharge.sv
module clim_discharge
    import clim_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             end_evt,
    input  logic             rise,
    input  logic [CNT_W-1:0] hold_len,
    output logic             node_reset
);

    node_state_e      st_q;
    logic [CNT_W-1:0] hold_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= NODES_SHORTED;
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (end_evt) begin
            st_q   <= NODES_SHORTED;
            hold_q <= CNT_W'(span_load(32'(hold_len)));
            pend_q <= 1'b0;
        end else if (st_q == NODES_SHORTED) begin
            if (hold_q == '0 && (pend_q || rise)) begin
                st_q   <= NODES_OPEN;
                pend_q <= 1'b0;
            end else begin
                if (hold_q != '0)
                    hold_q <= hold_q - 1'b1;
                if (rise)
                    pend_q <= 1'b1;
            end
        end
    end

    always_comb node_reset = (st_q == NODES_SHORTED);

    AST_END_SHORTS: assert property (@(posedge clk) disable iff (rst)
        end_evt |=> node_reset); // R5
    AST_OPEN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $fell(node_reset) |-> $past(rise || pend_q)); // R6
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (node_reset && hold_q != '0) |=> node_reset); // R6

endmodule

// File: rtl/pulse_limit.sv
module pulse_limit
    import clim_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_on,
    input  logic             oc_flag,
    input  logic             ramp_trip,
    input  logic             err_low,
    input  logic [CNT_W-1:0] blank_len,
    input  logic [CNT_W-1:0] hold_len,
    input  logic             oc_clr,
    output logic             end_pulse,
    output logic             node_reset,
    output logic             oc_seen
);

    pulse_ev_t ev;
    logic      trip;
    logic      blank_act;
    logic      end_evt;

    clim_pulse_track u_track (
        .clk      (clk),
        .rst      (rst),
        .pulse_on (pulse_on),
        .trip     (trip),
        .ev       (ev)
    );

    clim_blank #(.CNT_W(CNT_W)) u_blank (
        .clk       (clk),
        .rst       (rst),
        .rise      (ev.rise),
        .blank_len (blank_len),
        .blank_act (blank_act)
    );

    clim_trip u_trip (
        .clk       (clk),
        .rst       (rst),
        .live      (ev.live),
        .blank_act (blank_act),
        .oc_flag   (oc_flag),
        .ramp_trip (ramp_trip),
        .err_low   (err_low),
        .oc_clr    (oc_clr),
        .trip      (trip),
        .end_pulse (end_pulse),
        .oc_seen   (oc_seen)
    );

    always_comb end_evt = trip | ev.natural_end;

    clim_discharge #(.CNT_W(CNT_W)) u_dis (
        .clk        (clk),
        .rst        (rst),
        .end_evt    (end_evt),
        .rise       (ev.rise),
        .hold_len   (hold_len),
        .node_reset (node_reset)
    );

    AST_STROBE_SHORTS: assert property (@(posedge clk) disable iff (rst)
        end_pulse |-> node_reset); // R5

endmodule

// File: tb/pulse_limit_test.sv
module pulse_limit_test;

    localparam int CW = 4;
    localparam int NV = 23;

    logic          clk = 1'b0;
    logic          rst;
    logic          pulse_on, oc_flag, ramp_trip, err_low, oc_clr;
    logic [CW-1:0] blank_len, hold_len;
    logic          end_pulse, node_reset, oc_seen;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    always #5 clk = ~clk;

    pulse_limit #(.CNT_W(CW)) uut (
        .clk        (clk),
        .rst        (rst),
        .pulse_on   (pulse_on),
        .oc_flag    (oc_flag),
        .ramp_trip  (ramp_trip),
        .err_low    (err_low),
        .blank_len  (blank_len),
        .hold_len   (hold_len),
        .oc_clr     (oc_clr),
        .end_pulse  (end_pulse),
        .node_reset (node_reset),
        .oc_seen    (oc_seen)
    );

    // {req id, pulse_on oc ramp errlow clr, expected end_pulse node_reset oc_seen}
    // blank_len = 3, hold_len = 2
    localparam logic [11:0] VEC [0:NV-1] = '{
        {4'd1,  5'b00000, 3'b010},
        {4'd2,  5'b11000, 3'b000},
        {4'd2,  5'b11000, 3'b000},
        {4'd2,  5'b11000, 3'b000},
        {4'd3,  5'b11000, 3'b111},
        {4'd10, 5'b11000, 3'b011},
        {4'd5,  5'b00000, 3'b011},
        {4'd5,  5'b00000, 3'b011},
        {4'd6,  5'b10000, 3'b001},
        {4'd4,  5'b10100, 3'b111},
        {4'd5,  5'b00000, 3'b011},
        {4'd6,  5'b10000, 3'b001},
        {4'd2,  5'b11000, 3'b001},
        {4'd2,  5'b10000, 3'b001},
        {4'd5,  5'b00000, 3'b011},
        {4'd8,  5'b00001, 3'b010},
        {4'd7,  5'b10010, 3'b110},
        {4'd10, 5'b10010, 3'b010},
        {4'd5,  5'b00000, 3'b010},
        {4'd9,  5'b11000, 3'b000},
        {4'd9,  5'b11000, 3'b000},
        {4'd9,  5'b11000, 3'b000},
        {4'd9,  5'b11000, 3'b111}
    };

    function automatic string rname(int k);
        case (k)
            1:       return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            7:       return "R7";
            8:       return "R8";
            9:       return "R9";
            10:      return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        total++;
        if ({end_pulse, node_reset, oc_seen} !== exp) begin
            bad++;
            $display("FAIL %s: got ep/nr/seen=%b expected %b", req,
                     {end_pulse, node_reset, oc_seen}, exp);
        end
    endtask

    task automatic step(input logic [4:0] stim);
        @(negedge clk);
        {pulse_on, oc_flag, ramp_trip, err_low, oc_clr} = stim;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!fin) begin
            fin = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete, got hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        {pulse_on, oc_flag, ramp_trip, err_low, oc_clr} = '0;
        blank_len = CW'(3);
        hold_len  = CW'(2);
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 3'b010);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7:3]);
            check(rname(int'(VEC[i][11:8])), VEC[i][2:0]);
        end

        // R2: zero blanking cuts an overcurrent pulse at its first cycle
        @(negedge clk);
        blank_len = '0;
        step(5'b00000); check("R2 idle before zero blank", 3'b011);
        step(5'b11000); check("R2 no blanking", 3'b111);
        step(5'b00000); check("R5 held after cut", 3'b011);

        // R6: a new pulse arrives while the hold time is still running
        @(negedge clk);
        blank_len = CW'(3);
        hold_len  = CW'(4);
        step(5'b10000); check("R6 release at start", 3'b001);
        step(5'b00000); check("R5 natural end", 3'b011);
        step(5'b10000); check("R6 start during hold", 3'b011);
        step(5'b10000); check("R6 hold 2", 3'b011);
        step(5'b10000); check("R6 hold 3", 3'b011);
        step(5'b10000); check("R6 release after hold", 3'b001);

        // R8: set beats clear, then clear alone
        step(5'b11001); check("R8 set wins", 3'b111);
        step(5'b00001); check("R8 clear", 3'b010);

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 3'b010);
        @(negedge clk);
        rst = 1'b0;

        finish_run();
    end

endmodule